// File: doc/BRIEF.md
# Adjustable-Rate Time Counter

A free-running nanosecond counter for precision timestamping. On every enabled timer clock it adds a programmable step. With the normal step equal to the timer clock period in nanoseconds, the count is in 1 ns units. The frequency is trimmed by replacing the normal step with a separate correction step once every N enabled cycles. Wrap mode makes the count fold back at a programmable period, 2^31 after reset, so it behaves as a 31-bit counter. With wrap mode off it rolls over at its full 32-bit width.

Software controls the block through a small register port with five word addresses: 0 control, 1 time, 2 wrap period, 3 correction period, 4 step. Writing the time address loads the counter. A capture command in the control word copies the live count into a holding register, which the time address returns on a read. A restart command clears the count and the correction phase. The running count is also driven out continuously for nearby timestamping logic.

Top module: `adj_time_counter`

## Requirements
- R1: After a synchronous reset `cur_time` is 0, the wrap period reads back 0x8000_0000, and the control, correction-period and step registers read back 0.
- R2: While control bit 0 (enable) is set, `cur_time` grows each clock by the normal step held in step-register bits 6:0. While enable is clear and no write occurs, `cur_time` holds its value.
- R3: With a non-zero correction period P at address 3, every (P+1)-th enabled clock after a restart adds the correction step from step-register bits 14:8 instead of the normal step. With P = 0 the correction step is never used.
- R4: While either of control bits 5:4 (wrap mode) is set, a sum that reaches or passes the wrap period has the period subtracted. With period 100, a count of 95 and a step of 8, the next count is 3. With period 2^31 and a count of 0x7FFF_FFFC, the next count is 4.
- R5: With wrap mode off, the count rolls over modulo 2^32. 0x7FFF_FFFC plus 8 gives 0x8000_0004, and 0xFFFF_FFFC plus 8 gives 4.
- R6: A write to address 1 loads the written value into `cur_time` at that clock edge, whether or not the counter is enabled. No step is added on that edge.
- R7: Writing control with bit 9 (restart) set clears the count and the correction phase at that edge. Bit 9 always reads back 0.
- R8: Writing control with bit 11 (capture) set latches the count as it stood before that edge. Later reads of address 1 return the latched value. Bit 11 always reads back 0.
- R9: A read asserted in one cycle presents its data on `bus_rdata` after the next clock edge, and `bus_rdata` holds until the next read. Control reads back enable in bit 0 and wrap mode in bits 5:4. The step register reads back the normal step in bits 6:0 and the correction step in bits 14:8. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cur_time | output | 32 | Live counter value |

## Verification
The wrap-bound property assumes that both steps are no larger than the wrap period and that the count already lies below the period. A count loaded above the period is allowed to stay above it, so the property only fires from a count that is in range. The stimulus keeps the steps at 8 and 9, against periods of 100 and 2^31. It loads out-of-range counts only while wrap mode is off or the counter is stopped. Reads and writes are never issued in the same cycle, so the property relating a time write to the next count sees one bus operation at a time.

// File: rtl/atc_pkg.sv
package atc_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_CTRL   = 3'd0,
    RA_TIME   = 3'd1,
    RA_PERIOD = 3'd2,
    RA_CORR   = 3'd3,
    RA_STEP   = 3'd4
  } reg_addr_e;

  // control word bit positions
  localparam int CB_EN      = 0;
  localparam int CB_WRAP_LO = 4;
  localparam int CB_WRAP_HI = 5;
  localparam int CB_RESTART = 9;
  localparam int CB_CAPTURE = 11;

  // step word field positions
  localparam int SB_NORM_LSB = 0;
  localparam int SB_CORR_LSB = 8;
endpackage

// File: rtl/atc_regs.sv
module atc_regs
  import atc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INC_W  = 7,
  parameter int ADDR_W = 3,
  parameter logic [DATA_W-1:0] RST_PERIOD = DATA_W'(64'h8000_0000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] live_time,
  output logic              ctl_en,
  output logic              ctl_wrap,
  output logic [DATA_W-1:0] wrap_period,
  output logic [DATA_W-1:0] corr_period,
  output logic [INC_W-1:0]  step_norm,
  output logic [INC_W-1:0]  step_corr,
  output logic              load_stb,
  output logic              restart_stb,
  output logic [DATA_W-1:0] rdata
);
  logic              en_q;
  logic [1:0]        wrap_sel_q;
  logic [DATA_W-1:0] period_q;
  logic [DATA_W-1:0] corr_q;
  logic [INC_W-1:0]  norm_q;
  logic [INC_W-1:0]  cstep_q;
  logic [DATA_W-1:0] cap_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;

  logic wr_ctrl, wr_period, wr_corr, wr_step, capture_stb;

  always_comb begin
    wr_ctrl     = wr_en && (addr == ADDR_W'(RA_CTRL));
    wr_period   = wr_en && (addr == ADDR_W'(RA_PERIOD));
    wr_corr     = wr_en && (addr == ADDR_W'(RA_CORR));
    wr_step     = wr_en && (addr == ADDR_W'(RA_STEP));
    load_stb    = wr_en && (addr == ADDR_W'(RA_TIME));
    restart_stb = wr_ctrl && wdata[CB_RESTART];
    capture_stb = wr_ctrl && wdata[CB_CAPTURE];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      wrap_sel_q <= 2'b00;
      period_q   <= RST_PERIOD;
      corr_q     <= '0;
      norm_q     <= '0;
      cstep_q    <= '0;
      cap_q      <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q       <= wdata[CB_EN];
        wrap_sel_q <= wdata[CB_WRAP_HI:CB_WRAP_LO];
      end
      if (capture_stb) cap_q <= live_time;
      if (wr_period)   period_q <= wdata;
      if (wr_corr)     corr_q <= wdata;
      if (wr_step) begin
        norm_q  <= wdata[SB_NORM_LSB +: INC_W];
        cstep_q <= wdata[SB_CORR_LSB +: INC_W];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(RA_CTRL): begin
        rd_mux[CB_EN] = en_q;
        rd_mux[CB_WRAP_HI:CB_WRAP_LO] = wrap_sel_q;
      end
      ADDR_W'(RA_TIME):   rd_mux = cap_q;
      ADDR_W'(RA_PERIOD): rd_mux = period_q;
      ADDR_W'(RA_CORR):   rd_mux = corr_q;
      ADDR_W'(RA_STEP): begin
        rd_mux[SB_NORM_LSB +: INC_W] = norm_q;
        rd_mux[SB_CORR_LSB +: INC_W] = cstep_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign ctl_en      = en_q;
  assign ctl_wrap    = |wrap_sel_q;
  assign wrap_period = period_q;
  assign corr_period = corr_q;
  assign step_norm   = norm_q;
  assign step_corr   = cstep_q;
  assign rdata       = rdata_q;
endmodule

// File: rtl/atc_corr_timer.sv
module atc_corr_timer #(
  parameter int CP_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            restart,
  input  logic [CP_W-1:0] corr_period,
  output logic            corr_tick
);
  logic [CP_W-1:0] phase_q;
  logic            active;

  assign active    = en && (corr_period != '0);
  assign corr_tick = active && (phase_q >= corr_period);

  always_ff @(posedge clk) begin
    if (rst || restart)  phase_q <= '0;
    else if (en) begin
      if (!active || corr_tick) phase_q <= '0;
      else                      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/atc_count_core.sv
module atc_count_core #(
  parameter int CNT_W = 32,
  parameter int INC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wrap,
  input  logic [CNT_W-1:0] period,
  input  logic [INC_W-1:0] step_norm,
  input  logic [INC_W-1:0] step_corr,
  input  logic             corr_tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] count_q;
  logic [INC_W-1:0] step;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] folded;
  logic [CNT_W-1:0] next_count;

  always_comb begin
    step   = corr_tick ? step_corr : step_norm;
    sum    = {1'b0, count_q} + SUM_W'(step);
    folded = sum - {1'b0, period};
    if (wrap && (sum >= {1'b0, period})) next_count = folded[CNT_W-1:0];
    else                                 next_count = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || restart) count_q <= '0;
    else if (load)      count_q <= load_val;
    else if (en)        count_q <= next_count;
  end

  assign count = count_q;
endmodule

// File: rtl/adj_time_counter.sv
module adj_time_counter #(
  parameter int DATA_W = 32,
  parameter int INC_W  = 7,
  parameter int ADDR_W = 3,
  parameter logic [DATA_W-1:0] RST_PERIOD = DATA_W'(64'h8000_0000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] cur_time
);
  logic              ctl_en;
  logic              ctl_wrap;
  logic [DATA_W-1:0] wrap_period;
  logic [DATA_W-1:0] corr_period;
  logic [INC_W-1:0]  step_norm;
  logic [INC_W-1:0]  step_corr;
  logic              load_stb;
  logic              restart_stb;
  logic              corr_tick;
  logic [DATA_W-1:0] count;

  atc_regs #(
    .DATA_W(DATA_W), .INC_W(INC_W), .ADDR_W(ADDR_W), .RST_PERIOD(RST_PERIOD)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .live_time(count), .ctl_en(ctl_en), .ctl_wrap(ctl_wrap),
    .wrap_period(wrap_period), .corr_period(corr_period), .step_norm(step_norm),
    .step_corr(step_corr), .load_stb(load_stb), .restart_stb(restart_stb),
    .rdata(bus_rdata)
  );

  atc_corr_timer #(.CP_W(DATA_W)) u_corr (
    .clk(clk), .rst(rst), .en(ctl_en), .restart(restart_stb),
    .corr_period(corr_period), .corr_tick(corr_tick)
  );

  atc_count_core #(.CNT_W(DATA_W), .INC_W(INC_W)) u_core (
    .clk(clk), .rst(rst), .en(ctl_en), .wrap(ctl_wrap), .period(wrap_period),
    .step_norm(step_norm), .step_corr(step_corr), .corr_tick(corr_tick),
    .load(load_stb), .load_val(bus_wdata), .restart(restart_stb), .count(count)
  );

  assign cur_time = count;
endmodule

// File: rtl/adj_time_counter_chk.sv
module adj_time_counter_chk #(
  parameter int DATA_W = 32,
  parameter int INC_W  = 7,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] cur_time,
  input logic              ctl_en,
  input logic              ctl_wrap,
  input logic [DATA_W-1:0] wrap_period,
  input logic [DATA_W-1:0] corr_period,
  input logic [INC_W-1:0]  step_norm,
  input logic [INC_W-1:0]  step_corr,
  input logic              corr_tick
);
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> cur_time == '0);

  assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctl_en && !bus_wr) |=> $stable(cur_time));

  // R3: a correction step only happens on enabled cycles with a non-zero period
  assert_corr_gated_R3: assert property (@(posedge clk) disable iff (rst)
    corr_tick |-> (ctl_en && corr_period != '0));

  assert_wrap_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_en && ctl_wrap && !bus_wr && cur_time < wrap_period &&
     DATA_W'(step_norm) <= wrap_period && DATA_W'(step_corr) <= wrap_period)
    |=> cur_time < $past(wrap_period));

  assert_time_load_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(1)) |=> cur_time == $past(bus_wdata));

  assert_restart_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[9]) |=> cur_time == '0);
endmodule

bind adj_time_counter adj_time_counter_chk #(
  .DATA_W(DATA_W), .INC_W(INC_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cur_time(cur_time), .ctl_en(ctl_en),
  .ctl_wrap(ctl_wrap), .wrap_period(wrap_period), .corr_period(corr_period),
  .step_norm(step_norm), .step_corr(step_corr), .corr_tick(corr_tick)
);

// File: tb/adj_time_counter_tb.sv
`timescale 1ns/1ps
module adj_time_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] cur_time;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit live   = 0;

  always #10 clk = ~clk;

  adj_time_counter u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cur_time(cur_time)
  );

  // behavioural reference model
  longint unsigned m_cnt, m_cc, m_cap, m_per, m_cp, m_ni, m_ci, m_rd;
  longint unsigned n_cnt, n_cc, stepv, sumv;
  bit m_en;
  logic [1:0] m_ws;
  bit tick;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cc = 0; m_cap = 0; m_per = 64'h8000_0000; m_cp = 0;
      m_ni = 0; m_ci = 0; m_rd = 0; m_en = 0; m_ws = 0;
    end else begin
      n_cc = m_cc; tick = 0; n_cnt = m_cnt;
      if (m_en) begin
        if (m_cp == 0) n_cc = 0;
        else if (m_cc >= m_cp) begin tick = 1; n_cc = 0; end
        else n_cc = m_cc + 1;
        stepv = tick ? m_ci : m_ni;
        sumv  = m_cnt + stepv;
        if (m_ws != 0 && sumv >= m_per) sumv = sumv - m_per;
        n_cnt = sumv & 64'hFFFF_FFFF;
      end
      if (bus_rd) begin
        case (bus_addr)
          3'd0: m_rd = longint'(m_en) | (longint'(m_ws) << 4);
          3'd1: m_rd = m_cap;
          3'd2: m_rd = m_per;
          3'd3: m_rd = m_cp;
          3'd4: m_rd = m_ni | (m_ci << 8);
          default: m_rd = 0;
        endcase
      end
      if (bus_wr) begin
        case (bus_addr)
          3'd0: begin
            if (bus_wdata[11]) m_cap = m_cnt;
            m_en = bus_wdata[0];
            m_ws = bus_wdata[5:4];
            if (bus_wdata[9]) begin n_cnt = 0; n_cc = 0; end
          end
          3'd1: n_cnt = bus_wdata;
          3'd2: m_per = bus_wdata;
          3'd3: m_cp = bus_wdata;
          3'd4: begin m_ni = bus_wdata[6:0]; m_ci = bus_wdata[14:8]; end
          default: ;
        endcase
      end
      m_cnt = n_cnt; m_cc = n_cc;
    end
  end

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // compare with the model on every clock (R2 counting, R9 read path)
  always @(negedge clk) begin
    if (live && !rst) begin
      check("R2 model cur_time", cur_time, m_cnt);
      check("R9 model rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, t0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    live = 1;
    check("R1 reset time", cur_time, 0);
    rd(3'd2, d); check("R1 reset period", d, 32'h8000_0000);
    rd(3'd0, d); check("R1 reset ctrl", d, 0);
    rd(3'd4, d); check("R1 reset step", d, 0);
    rd(3'd3, d); check("R1 reset corr", d, 0);

    wr(3'd4, 32'h0000_0908);
    rd(3'd4, d); check("R9 step readback", d, 32'h0908);
    rd(3'd6, d); check("R9 unmapped", d, 0);

    // free run with 2^31 wrap, no correction
    wr(3'd0, 32'h11);
    rd(3'd0, d); check("R9 ctrl readback", d, 32'h11);
    repeat (20) @(negedge clk);

    // R3 with P=0: restart + enable, 4 edges of +8
    wr(3'd0, 32'h211);
    check("R7 restart clears", cur_time, 0);
    repeat (4) @(negedge clk);
    check("R3 no correction when P=0", cur_time, 32);

    // R3 with P=3: pattern 8,8,8,9
    wr(3'd3, 32'd3);
    wr(3'd0, 32'h211);
    check("R7 restart clears", cur_time, 0);
    repeat (8) @(negedge clk);
    check("R3 correction every 4th cycle", cur_time, 66);
    rd(3'd0, d); check("R7 restart bit reads 0", d, 32'h11);
    repeat (30) @(negedge clk);

    // R4 wrap at a small period
    wr(3'd3, 32'd0);
    wr(3'd0, 32'h10);
    wr(3'd2, 32'd100);
    wr(3'd1, 32'd95);
    check("R6 load while stopped", cur_time, 95);
    wr(3'd0, 32'h11);
    check("R2 enable edge adds nothing", cur_time, 95);
    @(negedge clk);
    check("R4 wrap remainder", cur_time, 3);
    repeat (40) @(negedge clk);

    // R4 at 2^31
    wr(3'd0, 32'h10);
    wr(3'd2, 32'h8000_0000);
    wr(3'd1, 32'h7FFF_FFFC);
    wr(3'd0, 32'h11);
    @(negedge clk);
    check("R4 wrap at 2^31", cur_time, 4);

    // R5 wrap off
    wr(3'd0, 32'h00);
    wr(3'd1, 32'h7FFF_FFFC);
    wr(3'd0, 32'h01);
    @(negedge clk);
    check("R5 no fold at period", cur_time, 32'h8000_0004);
    wr(3'd0, 32'h00);
    t0 = cur_time;
    repeat (5) @(negedge clk);
    check("R2 disabled hold", cur_time, t0);
    wr(3'd1, 32'hFFFF_FFFC);
    wr(3'd0, 32'h01);
    @(negedge clk);
    check("R5 full-width rollover", cur_time, 4);

    // R8 capture
    wr(3'd0, 32'h00);
    wr(3'd1, 32'h1234);
    wr(3'd0, 32'h800);
    rd(3'd1, d); check("R8 captured value", d, 32'h1234);
    rd(3'd0, d); check("R8 capture bit reads 0", d, 0);
    wr(3'd0, 32'h11);
    repeat (7) @(negedge clk);
    wr(3'd0, 32'h811);
    rd(3'd1, d); check("R8 running capture", d, m_cap);

    // R6 load while running
    wr(3'd1, 32'd500);
    check("R6 load while running", cur_time, 500);
    repeat (25) @(negedge clk);

    finish_run();
  end
endmodule